// File: doc/BRIEF.md
# Serial Converter Host Controller with Frame-Sync or Chip-Select Framing

This block is the master end of a three-wire serial link to a 14-bit sampling converter. A one-clock `start` request runs one complete transaction. The block frames the transaction, sends a fixed burst of serial clocks while it shifts the returned data into a parallel word, and then keeps the link quiet for a programmable conversion interval. A new transaction can begin only after that interval.

Framing is chosen per transaction with the `fs_mode` input. In chip-select framing, `adc_cs_n` goes low for the whole transaction, including the conversion interval, and returns high when the transaction ends. In frame-sync framing, `adc_cs_n` is held low and a frame-sync pulse one serial-clock period wide comes before the clock burst. The converter wakes from its power-down state on either framing edge, so the block sends no separate wake-up action.

The serial clock is the system clock divided by `2*HALF_DIV`. The converter always returns the word from the sample taken in the previous transaction. For this reason, the first transaction after reset only primes the pipeline and produces no result strobe.

Top module: `fsadc_host`

## Requirements
- R1: While reset is asserted, and until the next start, outputs are idle: `adc_cs_n`=1, `adc_fs`=0, `adc_sclk`=0, `busy`=0, `result_valid`=0.
- R2: With `fs_mode`=0 sampled at start, `adc_cs_n` falls and `busy` rises on the clock after start. `adc_cs_n` stays low for as long as `busy` is high, and it returns high on the same clock on which `busy` falls.
- R3: With `fs_mode`=1 sampled at start, `adc_cs_n` is low throughout the transaction and remains low after it. `adc_fs` is high for exactly 2*HALF_DIV system clocks, starting on the clock after start. `adc_sclk` stays low while `adc_fs` is high.
- R4: Each transaction has exactly 24 SCLK pulses, each with HALF_DIV system clocks high and HALF_DIV low. `adc_sclk` is low whenever `busy` is low.
- R5: `adc_sdo` is sampled on the system clock edge where `adc_sclk` falls. The first 14 samples form `result`, most significant bit first.
- R6: After a primed transaction, `result_valid` is high for exactly one system clock, on the clock after the 14th SCLK falling edge. `result` changes only when `result_valid` is high.
- R7: The first transaction after any reset gives no `result_valid` pulse.
- R8: After the 24th falling edge, `busy` stays high for `conv_wait` more system clocks, with a value of 0 treated as 1. `busy` is therefore high for 48*HALF_DIV + max(conv_wait,1) clocks, plus 2*HALF_DIV clocks in frame-sync framing.
- R9: `start` is ignored while `busy` is high and is not queued. `fs_mode` and `conv_wait` are captured at start, and later changes do not affect the running transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request one transaction (sampled when idle) |
| fs_mode | input | 1 | 1 = frame-sync framing, 0 = chip-select framing |
| conv_wait | input | WAIT_W | Conversion interval in system clocks |
| busy | output | 1 | Transaction in progress |
| adc_cs_n | output | 1 | Chip-select to converter, active low |
| adc_fs | output | 1 | Frame-sync to converter |
| adc_sclk | output | 1 | Serial clock to converter |
| adc_sdo | input | 1 | Serial data from converter |
| result | output | N_BITS | Last captured word |
| result_valid | output | 1 | One-clock strobe for a new `result` |

## Verification
The assertions check on every cycle that chip-select stays low while busy, that the serial clock and frame-sync never overlap and rest low when idle, and that the result strobe is one clock wide and moves `result` only when it fires. The bench scenarios are what show the exact counts: 24 pulses, the length of the frame-sync pulse, and the total busy time for several `conv_wait` values including zero. The scenarios also cover the priming rule after a power-on reset and after a reset in mid-transaction, the bit order of the captured words, and the handling of a start request and input changes that arrive mid-transaction.

// File: rtl/fsadc_pkg.sv
package fsadc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_SHIFT = 2'd2,
    ST_WAIT  = 2'd3
  } seq_state_e;

  typedef enum logic {
    FRAME_CS = 1'b0,
    FRAME_FS = 1'b1
  } frame_mode_e;

endpackage

// File: rtl/fsadc_sclk_gen.sv
// Half-period divider and serial clock generator.
module fsadc_sclk_gen #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,        // divider counts while high
  input  logic toggle_en,  // serial clock toggles on ticks while high
  output logic tick,
  output logic fall,
  output logic sclk
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;

  assign tick = run && (cnt_q == LAST);
  assign fall = tick && toggle_en && sclk_q;
  assign sclk = sclk_q;

  always_comb begin
    cnt_d  = cnt_q;
    sclk_d = sclk_q;
    if (!run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
    if (!run || !toggle_en) begin
      sclk_d = 1'b0;
    end else if (tick) begin
      sclk_d = ~sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

endmodule

// File: rtl/fsadc_capture.sv
// Shift register sampling serial data on SCLK falling edges.
module fsadc_capture #(
  parameter int N_BITS = 14,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic [IDX_W-1:0]  fall_idx,
  input  logic              sdo,
  input  logic              primed,
  output logic [N_BITS-1:0] result,
  output logic              valid
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_BITS - 1);
  localparam logic [IDX_W-1:0] NB_IDX   = IDX_W'(N_BITS);

  logic [N_BITS-1:0] sh_q, sh_d;
  logic [N_BITS-1:0] res_q, res_d;
  logic              valid_q, valid_d;
  logic              take, last;

  assign take = fall && (fall_idx < NB_IDX);
  assign last = fall && (fall_idx == LAST_IDX);

  always_comb begin
    sh_d    = sh_q;
    res_d   = res_q;
    valid_d = 1'b0;
    if (take) begin
      sh_d = {sh_q[N_BITS-2:0], sdo};
    end
    if (last && primed) begin
      res_d   = sh_d;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q    <= '0;
      res_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      sh_q    <= sh_d;
      res_q   <= res_d;
      valid_q <= valid_d;
    end
  end

  assign result = res_q;
  assign valid  = valid_q;

endmodule

// File: rtl/fsadc_seq.sv
// Transaction sequencer: framing, clock burst, conversion wait.
module fsadc_seq
  import fsadc_pkg::*;
#(
  parameter int N_SCLK = 24,
  parameter int WAIT_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fs_mode,
  input  logic [WAIT_W-1:0] conv_wait,
  input  logic              tick,
  input  logic              fall,
  output logic              busy,
  output logic              run,
  output logic              toggle_en,
  output logic              cs_n,
  output logic              fs,
  output logic [IDX_W-1:0]  fall_idx,
  output logic              primed
);

  localparam logic [IDX_W-1:0] LAST_FALL = IDX_W'(N_SCLK - 1);

  seq_state_e        state_q, state_d;
  frame_mode_e       mode_q, mode_d;
  logic [WAIT_W-1:0] wait_q, wait_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              pre_half_q, pre_half_d;
  logic              cs_n_q, cs_n_d;
  logic              fs_q, fs_d;
  logic              primed_q, primed_d;

  always_comb begin
    state_d    = state_q;
    mode_d     = mode_q;
    wait_d     = wait_q;
    idx_d      = idx_q;
    pre_half_d = pre_half_q;
    cs_n_d     = cs_n_q;
    fs_d       = fs_q;
    primed_d   = primed_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          mode_d = frame_mode_e'(fs_mode);
          wait_d = conv_wait;
          idx_d  = '0;
          cs_n_d = 1'b0;
          if (fs_mode) begin
            state_d    = ST_PRE;
            fs_d       = 1'b1;
            pre_half_d = 1'b0;
          end else begin
            state_d = ST_SHIFT;
          end
        end
      end
      ST_PRE: begin
        if (tick) begin
          if (pre_half_q) begin
            state_d = ST_SHIFT;
            fs_d    = 1'b0;
          end else begin
            pre_half_d = 1'b1;
          end
        end
      end
      ST_SHIFT: begin
        if (fall) begin
          if (idx_q == LAST_FALL) begin
            state_d  = ST_WAIT;
            idx_d    = '0;
            primed_d = 1'b1;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (wait_q <= WAIT_W'(1)) begin
          state_d = ST_IDLE;
          cs_n_d  = (mode_q == FRAME_CS);
        end else begin
          wait_d = wait_q - 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mode_q     <= FRAME_CS;
      wait_q     <= '0;
      idx_q      <= '0;
      pre_half_q <= 1'b0;
      cs_n_q     <= 1'b1;
      fs_q       <= 1'b0;
      primed_q   <= 1'b0;
    end else begin
      state_q    <= state_d;
      mode_q     <= mode_d;
      wait_q     <= wait_d;
      idx_q      <= idx_d;
      pre_half_q <= pre_half_d;
      cs_n_q     <= cs_n_d;
      fs_q       <= fs_d;
      primed_q   <= primed_d;
    end
  end

  assign busy      = (state_q != ST_IDLE);
  assign run       = (state_q == ST_PRE) || (state_q == ST_SHIFT);
  assign toggle_en = (state_q == ST_SHIFT);
  assign cs_n      = cs_n_q;
  assign fs        = fs_q;
  assign fall_idx  = idx_q;
  assign primed    = primed_q;

endmodule

// File: rtl/fsadc_host.sv
// Top level: serial converter host controller.
module fsadc_host #(
  parameter int HALF_DIV = 2,
  parameter int N_BITS   = 14,
  parameter int N_SCLK   = 24,
  parameter int WAIT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              fs_mode,
  input  logic [WAIT_W-1:0] conv_wait,
  output logic              busy,
  output logic              adc_cs_n,
  output logic              adc_fs,
  output logic              adc_sclk,
  input  logic              adc_sdo,
  output logic [N_BITS-1:0] result,
  output logic              result_valid
);

  localparam int IDX_W = $clog2(N_SCLK);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= 2'b00;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end
  assign rst_core_n = rst_pipe_q[1];

  logic             tick, fall, run, toggle_en, primed;
  logic [IDX_W-1:0] fall_idx;

  fsadc_seq #(
    .N_SCLK (N_SCLK),
    .WAIT_W (WAIT_W),
    .IDX_W  (IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (start),
    .fs_mode   (fs_mode),
    .conv_wait (conv_wait),
    .tick      (tick),
    .fall      (fall),
    .busy      (busy),
    .run       (run),
    .toggle_en (toggle_en),
    .cs_n      (adc_cs_n),
    .fs        (adc_fs),
    .fall_idx  (fall_idx),
    .primed    (primed)
  );

  fsadc_sclk_gen #(
    .HALF_DIV (HALF_DIV)
  ) u_sclk (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .run       (run),
    .toggle_en (toggle_en),
    .tick      (tick),
    .fall      (fall),
    .sclk      (adc_sclk)
  );

  fsadc_capture #(
    .N_BITS (N_BITS),
    .IDX_W  (IDX_W)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .fall     (fall),
    .fall_idx (fall_idx),
    .sdo      (adc_sdo),
    .primed   (primed),
    .result   (result),
    .valid    (result_valid)
  );

endmodule

// File: rtl/fsadc_host_chk.sv
// Property checker bound to the host controller.
module fsadc_host_chk #(
  parameter int N_BITS = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              adc_cs_n,
  input logic              adc_fs,
  input logic              adc_sclk,
  input logic [N_BITS-1:0] result,
  input logic              result_valid
);

  AST_CS_LOW_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !adc_cs_n); // R2

  AST_FS_EXCLUDES_SCLK: assert property (@(posedge clk) disable iff (!rst_n)
    adc_fs |-> (!adc_sclk && busy)); // R3

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !adc_sclk); // R4

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid); // R6

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !result_valid |-> $stable(result)); // R6

  AST_VALID_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (busy && !adc_fs)); // R5

endmodule

bind fsadc_host fsadc_host_chk #(.N_BITS(N_BITS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .adc_cs_n     (adc_cs_n),
  .adc_fs       (adc_fs),
  .adc_sclk     (adc_sclk),
  .result       (result),
  .result_valid (result_valid)
);

// File: tb/fsadc_host_bench.sv
module fsadc_host_bench;

  localparam int HALF = 2;
  localparam int NB   = 14;
  localparam int NV   = 6;

  // {fs_mode, conv_wait[15:0], converter word[13:0]}
  localparam logic [30:0] VECS [0:NV-1] = '{
    {1'b0, 16'd5,  14'h3FFF},
    {1'b0, 16'd0,  14'h0000},
    {1'b1, 16'd1,  14'h2AAA},
    {1'b1, 16'd40, 14'h1555},
    {1'b0, 16'd3,  14'h2001},
    {1'b1, 16'd17, 14'h1234}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          fs_mode = 1'b0;
  logic [15:0]   conv_wait = 16'd0;
  logic          busy, adc_cs_n, adc_fs, adc_sclk;
  logic          adc_sdo = 1'b0;
  logic [NB-1:0] result;
  logic          result_valid;

  logic [NB-1:0] adc_word = '0;
  int            bit_idx = 0;
  int            n_chk = 0;
  int            n_bad = 0;

  always #2 clk = ~clk;

  fsadc_host #(.HALF_DIV(HALF)) u_fsadc_host (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .fs_mode      (fs_mode),
    .conv_wait    (conv_wait),
    .busy         (busy),
    .adc_cs_n     (adc_cs_n),
    .adc_fs       (adc_fs),
    .adc_sclk     (adc_sclk),
    .adc_sdo      (adc_sdo),
    .result       (result),
    .result_valid (result_valid)
  );

  // converter model: next bit on each rising SCLK edge
  always @(posedge adc_sclk) begin
    if (bit_idx < NB) adc_sdo = adc_word[NB-1-bit_idx];
    else              adc_sdo = 1'b0;
    bit_idx = bit_idx + 1;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk(tag, int'(adc_cs_n), 1);
    chk(tag, int'(adc_fs), 0);
    chk(tag, int'(adc_sclk), 0);
    chk(tag, int'(busy), 0);
    chk(tag, int'(result_valid), 0);
  endtask

  task automatic run_cycle(input logic mode, input logic [15:0] w,
                           input logic [NB-1:0] word, input logic exp_valid,
                           input logic inject);
    int busy_n = 0;
    int rise_n = 0;
    int fs_n = 0;
    int cs_hi = 0;
    int val_n = 0;
    int guard = 0;
    int exp_busy;
    logic prev_sclk = 1'b0;
    logic [NB-1:0] got = '0;
    adc_word  = word;
    bit_idx   = 0;
    fs_mode   = mode;
    conv_wait = w;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy && guard < 5000) begin
      busy_n++;
      if (adc_sclk && !prev_sclk) rise_n++;
      prev_sclk = adc_sclk;
      if (adc_fs) fs_n++;
      if (adc_cs_n) cs_hi++;
      if (result_valid) begin
        val_n++;
        got = result;
      end
      if (inject && busy_n == 20) begin
        start     = 1'b1;
        fs_mode   = ~mode;
        conv_wait = 16'd100;
      end
      if (inject && busy_n == 21) start = 1'b0;
      @(negedge clk);
      guard++;
    end
    exp_busy = 48*HALF + ((w == 16'd0) ? 1 : int'(w)) + (mode ? 2*HALF : 0);
    chk(inject ? "R9 busy length" : "R8 busy length", busy_n, exp_busy);
    chk("R4 pulse count", rise_n, 24);
    chk("R3 fs width", fs_n, mode ? 2*HALF : 0);
    chk("R2 cs low while busy", cs_hi, 0);
    if (exp_valid) begin
      chk("R6 one strobe", val_n, 1);
      chk("R5 data order", int'(got), int'(word));
    end else begin
      chk("R7 no strobe when unprimed", val_n, 0);
    end
    chk(mode ? "R3 cs held low" : "R2 cs released", int'(adc_cs_n), mode ? 0 : 1);
    chk("R4 sclk idle", int'(adc_sclk), 0);
    fs_mode = mode;
    if (inject) begin
      @(negedge clk);
      chk("R9 start not queued", int'(busy), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 during reset");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_idle("R1 after release");

    // table walk: first entry is the unprimed transaction
    for (int i = 0; i < NV; i++) begin
      run_cycle(VECS[i][30], VECS[i][29:14], VECS[i][13:0], (i != 0), 1'b0);
      repeat (2) @(negedge clk);
    end

    // start request and input changes in mid-transaction
    run_cycle(1'b0, 16'd7, 14'h0F0F, 1'b1, 1'b1);
    repeat (2) @(negedge clk);

    // reset in mid-transaction
    fs_mode   = 1'b0;
    conv_wait = 16'd9;
    start     = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_idle("R1 reset mid-transaction");
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk_idle("R1 idle after release");
    run_cycle(1'b0, 16'd2, 14'h3C3C, 1'b0, 1'b0);
    repeat (2) @(negedge clk);
    run_cycle(1'b0, 16'd2, 14'h0001, 1'b1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule